// File: doc/BRIEF.md
# Flash Block Protection Unit

This unit sits beside the array controller of a 1M-word, 16-bit flash device. It translates a word address into one of 39 erase blocks of uneven size and rules on whether a requested operation may go ahead. It gives that ruling on program, block erase, whole-array erase and lock maintenance requests. The unit does not touch the array and knows nothing of operation timing. Its whole job is a combinational verdict plus the lock state it keeps in registers.

Protection has two levels. Each block owns a lock flag, and one sticky master flag freezes every lock flag once it is set. Only the power-on reset clears the master flag. A write-protect input, active low, pins the two top blocks shut while it is driven low. Every request gets back, one cycle later, a single-cycle grant or deny pulse together with the index of the block it resolved to.

Top module: `flash_guard`

## Requirements
- R1: Block index: an address below 0xF8000 maps to addr[19:15] (blocks 0 to 30, 32K words each). Addresses 0xF8000 to 0xFDFFF map to blocks 31 to 36, and 0xFE000 to 0xFFFFF map to blocks 37 and 38 (4K words each). The index is 31 + addr[14:12] in both small-block ranges. Blocks 37 and 38 are the boot blocks.
- R2: A request sampled with req_valid high produces exactly one of rsp_grant or rsp_deny in the next cycle, for one cycle, with rsp_block holding the resolved index. Without a request, both pulses stay low.
- R3: Program (req_op 1) and block erase (req_op 2) are granted exactly when the addressed block is not effectively locked.
- R4: Set-lock (req_op 4) is granted when the master flag is clear and the target is not a boot block with wp_n low. A grant sets that block's lock flag.
- R5: Clear-locks (req_op 6) is granted when the master flag is clear. It clears every main and parameter lock flag. It clears the boot flags only if wp_n is high, and otherwise leaves them unchanged.
- R6: Set-master (req_op 5) is always granted and sets the master flag. From then on, every set-lock and clear-locks request is denied and no lock flag changes. Only rst clears the master flag.
- R7: While wp_n is low, the boot blocks count as locked whatever their flags hold. While wp_n is high, they follow only their own flags.
- R8: Whole-array erase (req_op 3) is granted only if no block is effectively locked, and it changes no lock state.
- R9: Op codes 0 and 7 are denied and change no state.
- R10: rst (synchronous, active high) clears all lock flags and the master flag, and drives both response pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (see R3 to R9) |
| req_addr | input | 20 | Word address of the target |
| wp_n | input | 1 | Write protect, active low |
| rsp_grant | output | 1 | One-cycle grant pulse |
| rsp_deny | output | 1 | One-cycle deny pulse |
| rsp_block | output | 6 | Resolved block index of the answered request |

## Verification
The assertions assume that req_op, req_addr and wp_n are settled whenever req_valid is high at a clock edge. They also assume the address never exceeds 20 bits, so every index lands below 39. The bench changes all request inputs together on the falling edge and holds them through the following rising edge. It drives wp_n as part of each request rather than on its own. It also issues a request on every cycle of the vector walk, so back-to-back decisions see the lock state that the previous request left behind.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
    localparam int ADDR_W      = 20;
    localparam int MAIN_SHIFT  = 15;
    localparam int SMALL_SHIFT = 12;
    localparam int N_MAIN      = 31;
    localparam int N_PARAM     = 6;
    localparam int N_BOOT      = 2;
    localparam int N_BLK       = N_MAIN + N_PARAM + N_BOOT;
    localparam int IDX_W       = $clog2(N_BLK);
    localparam int FIRST_BOOT  = N_MAIN + N_PARAM;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_PROG     = 3'd1,
        OP_ERASE    = 3'd2,
        OP_CHIP     = 3'd3,
        OP_SET_LOCK = 3'd4,
        OP_SET_PERM = 3'd5,
        OP_CLR_LOCK = 3'd6,
        OP_RSVD     = 3'd7
    } op_e;

    typedef struct packed {
        logic             grant;
        logic [IDX_W-1:0] blk;
    } verdict_t;

    typedef struct packed {
        logic             set_en;
        logic [IDX_W-1:0] set_idx;
        logic             clr_en;
        logic             clr_boot;
        logic             perm_set;
    } lock_upd_t;
endpackage

// File: rtl/flash_guard_map.sv
module flash_guard_map
    import flash_guard_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int IW   = IDX_W,
    parameter int NM   = N_MAIN,
    parameter int MSH  = MAIN_SHIFT,
    parameter int SSH  = SMALL_SHIFT,
    parameter int FB   = FIRST_BOOT
) (
    input  logic [AW-1:0] addr,
    output logic [IW-1:0] idx,
    output logic          is_boot
);
    localparam logic [AW-1:0] MAIN_END = AW'(NM) << MSH;

    logic [AW-1:0] off;

    always_comb begin
        off = addr - MAIN_END;
        if (addr < MAIN_END)
            idx = IW'(addr >> MSH);
        else
            idx = IW'(NM) + IW'(off >> SSH);
        is_boot = (idx >= IW'(FB));
    end
endmodule

// File: rtl/flash_guard_locks.sv
module flash_guard_locks
    import flash_guard_pkg::*;
#(
    parameter int NB = N_BLK,
    parameter int IW = IDX_W,
    parameter int FB = FIRST_BOOT
) (
    input  logic          clk,
    input  logic          rst,
    input  lock_upd_t     upd,
    output logic [NB-1:0] lock_q,
    output logic          perm_q
);
    always_ff @(posedge clk) begin
        if (rst)               perm_q <= 1'b0;
        else if (upd.perm_set) perm_q <= 1'b1;
    end

    for (genvar b = 0; b < NB; b++) begin : g_bit
        localparam bit BOOT = (b >= FB);
        always_ff @(posedge clk) begin
            if (rst)
                lock_q[b] <= 1'b0;
            else if (upd.clr_en && (!BOOT || upd.clr_boot))
                lock_q[b] <= 1'b0;
            else if (upd.set_en && upd.set_idx == IW'(b))
                lock_q[b] <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_guard_policy.sv
module flash_guard_policy
    import flash_guard_pkg::*;
#(
    parameter int NB = N_BLK,
    parameter int IW = IDX_W,
    parameter int FB = FIRST_BOOT
) (
    input  logic          valid,
    input  op_e           op,
    input  logic [IW-1:0] idx,
    input  logic          is_boot,
    input  logic          wp_n,
    input  logic [NB-1:0] lock_q,
    input  logic          perm_q,
    output logic          grant,
    output lock_upd_t     upd
);
    logic [NB-1:0] boot_mask;
    logic [NB-1:0] eff_lock;

    for (genvar b = 0; b < NB; b++) begin : g_mask
        assign boot_mask[b] = (b >= FB);
    end

    assign eff_lock = lock_q | (boot_mask & {NB{~wp_n}});

    always_comb begin
        grant = 1'b0;
        upd   = '0;
        upd.set_idx  = idx;
        upd.clr_boot = wp_n;
        unique case (op)
            OP_PROG, OP_ERASE: grant = !eff_lock[idx];
            OP_CHIP:           grant = (eff_lock == '0);
            OP_SET_LOCK:       grant = !perm_q && !(is_boot && !wp_n);
            OP_SET_PERM:       grant = 1'b1;
            OP_CLR_LOCK:       grant = !perm_q;
            default:           grant = 1'b0;
        endcase
        if (valid && grant) begin
            upd.set_en   = (op == OP_SET_LOCK);
            upd.clr_en   = (op == OP_CLR_LOCK);
            upd.perm_set = (op == OP_SET_PERM);
        end
    end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
    import flash_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wp_n,
    output logic              rsp_grant,
    output logic              rsp_deny,
    output logic [IDX_W-1:0]  rsp_block
);
    logic [IDX_W-1:0] blk_idx;
    logic             blk_is_boot;
    logic [N_BLK-1:0] lock_q;
    logic             perm_q;
    logic             grant_c;
    lock_upd_t        upd;
    verdict_t         verdict_q;
    logic             pulse_q;

    flash_guard_map u_map (
        .addr    (req_addr),
        .idx     (blk_idx),
        .is_boot (blk_is_boot)
    );

    flash_guard_policy u_policy (
        .valid   (req_valid),
        .op      (op_e'(req_op)),
        .idx     (blk_idx),
        .is_boot (blk_is_boot),
        .wp_n    (wp_n),
        .lock_q  (lock_q),
        .perm_q  (perm_q),
        .grant   (grant_c),
        .upd     (upd)
    );

    flash_guard_locks u_locks (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .lock_q (lock_q),
        .perm_q (perm_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q   <= 1'b0;
            verdict_q <= '0;
        end else begin
            pulse_q <= req_valid;
            if (req_valid) begin
                verdict_q.grant <= grant_c;
                verdict_q.blk   <= blk_idx;
            end
        end
    end

    assign rsp_grant = pulse_q && verdict_q.grant;
    assign rsp_deny  = pulse_q && !verdict_q.grant;
    assign rsp_block = verdict_q.blk;
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk
    import flash_guard_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [2:0]       req_op,
    input logic             wp_n,
    input logic             rsp_grant,
    input logic             rsp_deny,
    input logic [IDX_W-1:0] rsp_block,
    input logic             blk_is_boot,
    input logic [N_BLK-1:0] lock_q,
    input logic             perm_q
);
    // R2: a request is answered by exactly one pulse
    a_r2_one_answer: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_grant ^ rsp_deny));
    // R2: no request, no pulse
    a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_grant && !rsp_deny));
    // R1: index in range whenever reported
    a_r1_index_range: assert property (@(posedge clk) disable iff (rst)
        (rsp_grant || rsp_deny) |-> (rsp_block < IDX_W'(N_BLK)));
    // R6: master flag is sticky
    a_r6_perm_sticky: assert property (@(posedge clk) disable iff (rst)
        perm_q |=> perm_q);
    // R6: lock flags frozen under master flag
    a_r6_locks_frozen: assert property (@(posedge clk) disable iff (rst)
        perm_q |=> $stable(lock_q));
    // R4: set-lock under master flag is refused
    a_r4_set_refused: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd4 && perm_q) |=> rsp_deny);
    // R7: boot program with protect low is refused
    a_r7_boot_guard: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd1 && blk_is_boot && !wp_n) |=> rsp_deny);
    // R10: reset clears state and pulses
    a_r10_reset_state: assert property (@(posedge clk)
        rst |=> (lock_q == '0 && !perm_q && !rsp_grant && !rsp_deny));
endmodule

bind flash_guard flash_guard_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .wp_n        (wp_n),
    .rsp_grant   (rsp_grant),
    .rsp_deny    (rsp_deny),
    .rsp_block   (rsp_block),
    .blk_is_boot (blk_is_boot),
    .lock_q      (lock_q),
    .perm_q      (perm_q)
);

// File: tb/flash_guard_test.sv
module flash_guard_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 30;
    // {op[30:28], wp_n[27], addr[26:7], grant[6], block[5:0]}
    localparam logic [30:0] TBL [NV] = '{
        {3'd1, 1'b1, 20'h00000, 1'b1, 6'd0 },  // R1 R3 first main
        {3'd1, 1'b1, 20'hF7FFF, 1'b1, 6'd30},  // R1 last main
        {3'd1, 1'b1, 20'hF8000, 1'b1, 6'd31},  // R1 first param
        {3'd2, 1'b1, 20'hFDFFF, 1'b1, 6'd36},  // R1 last param
        {3'd1, 1'b1, 20'hFE000, 1'b1, 6'd37},  // R1 R7 boot, wp high
        {3'd2, 1'b1, 20'hFFFFF, 1'b1, 6'd38},  // R1 top boot
        {3'd3, 1'b1, 20'h12345, 1'b1, 6'd2 },  // R8 nothing locked
        {3'd4, 1'b1, 20'h08000, 1'b1, 6'd1 },  // R4 lock block 1
        {3'd1, 1'b1, 20'h08ABC, 1'b0, 6'd1 },  // R3 locked
        {3'd3, 1'b1, 20'h00000, 1'b0, 6'd0 },  // R8 one locked
        {3'd1, 1'b1, 20'h10000, 1'b1, 6'd2 },  // R3 neighbour free
        {3'd1, 1'b0, 20'hFE000, 1'b0, 6'd37},  // R7 wp low
        {3'd4, 1'b0, 20'hFF000, 1'b0, 6'd38},  // R4 boot lock refused
        {3'd1, 1'b1, 20'hFF000, 1'b1, 6'd38},  // R4 flag not set
        {3'd4, 1'b1, 20'hFF000, 1'b1, 6'd38},  // R4 boot lock wp high
        {3'd6, 1'b0, 20'h00000, 1'b1, 6'd0 },  // R5 clear, wp low
        {3'd1, 1'b1, 20'h08000, 1'b1, 6'd1 },  // R5 main cleared
        {3'd1, 1'b1, 20'hFFFFF, 1'b0, 6'd38},  // R5 boot kept
        {3'd7, 1'b1, 20'h00000, 1'b0, 6'd0 },  // R9 code 7
        {3'd0, 1'b1, 20'h08000, 1'b0, 6'd1 },  // R9 code 0
        {3'd6, 1'b1, 20'h00000, 1'b1, 6'd0 },  // R5 clear, wp high
        {3'd1, 1'b1, 20'hFF000, 1'b1, 6'd38},  // R5 boot cleared
        {3'd4, 1'b1, 20'hFA000, 1'b1, 6'd33},  // R4 param lock
        {3'd5, 1'b1, 20'h00000, 1'b1, 6'd0 },  // R6 set master
        {3'd4, 1'b1, 20'h00000, 1'b0, 6'd0 },  // R6 set-lock refused
        {3'd6, 1'b1, 20'h00000, 1'b0, 6'd0 },  // R6 clear refused
        {3'd1, 1'b1, 20'hFA123, 1'b0, 6'd33},  // R6 lock survives
        {3'd1, 1'b1, 20'hF9000, 1'b1, 6'd32},  // R3 free param
        {3'd5, 1'b1, 20'h00000, 1'b1, 6'd0 },  // R6 master again
        {3'd3, 1'b1, 20'h00000, 1'b0, 6'd0 }   // R8 param locked
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic [19:0] req_addr = 20'd0;
    logic       wp_n = 1'b1;
    logic       rsp_grant, rsp_deny;
    logic [5:0] rsp_block;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_guard uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .wp_n(wp_n), .rsp_grant(rsp_grant),
        .rsp_deny(rsp_deny), .rsp_block(rsp_block)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ask(input logic [2:0] op, input logic w, input logic [19:0] a);
        req_valid = 1'b1; req_op = op; wp_n = w; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R10 reset pulses", {6'd0, rsp_grant, rsp_deny}, 8'd0);
        for (int i = 0; i < NV; i++) begin
            req_valid = 1'b1;
            req_op    = TBL[i][30:28];
            wp_n      = TBL[i][27];
            req_addr  = TBL[i][26:7];
            @(negedge clk);
            check($sformatf("R2 vector %0d verdict", i), {6'd0, rsp_grant, rsp_deny},
                  {6'd0, TBL[i][6], !TBL[i][6]});
            check($sformatf("R1 vector %0d block", i), {2'd0, rsp_block}, {2'd0, TBL[i][5:0]});
        end
        req_valid = 1'b0;
        @(negedge clk);
        check("R2 idle quiet", {6'd0, rsp_grant, rsp_deny}, 8'd0);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10 pulses low after reset", {6'd0, rsp_grant, rsp_deny}, 8'd0);
        ask(3'd1, 1'b1, 20'hFA000);
        check("R10 param lock gone", {6'd0, rsp_grant, rsp_deny}, 8'd2);
        ask(3'd4, 1'b1, 20'h00000);
        check("R10 master cleared", {6'd0, rsp_grant, rsp_deny}, 8'd2);
        ask(3'd6, 1'b1, 20'h00000);
        check("R5 clear granted", {6'd0, rsp_grant, rsp_deny}, 8'd2);
        ask(3'd3, 1'b0, 20'h00000);
        check("R7 R8 wp low blocks chip erase", {6'd0, rsp_grant, rsp_deny}, 8'd1);
        ask(3'd3, 1'b1, 20'h00000);
        check("R8 chip erase free", {6'd0, rsp_grant, rsp_deny}, 8'd2);
        @(negedge clk);
        check("R2 single pulse", {6'd0, rsp_grant, rsp_deny}, 8'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule